// File: doc/BRIEF.md
# Byte-to-Halfword SRAM Bridge

This block lets a CPU with an 8-bit data bus and an 18-bit byte address use an external asynchronous static RAM that is organised as 16-bit words, with one active-low write strobe per byte lane. The upper byte-address bits form the word address. The lowest byte-address bit picks the lane. That lane receives the write strobe and the driven write byte, and its byte is the one returned on a read.

The bridge runs from a clock at twice the CPU rate. It derives a CPU-phase signal internally by toggling a register on every fast edge. A lane's write strobe is pulled low only while that phase is high, so every CPU write cycle produces exactly one fast-clock-wide strobe. The bidirectional SRAM data bus is modelled as three separate vectors: an output vector, a per-lane output-enable vector and an input vector. The pad ring combines them.

Top module: `sram_lane_bridge`

## Requirements
- R1: The SRAM word address `sramAddr` equals byte address bits 17..1 whenever chip select is high.
- R2: A write with address bit 0 = 0 pulls only `sramWeN[0]` low; `sramWeN[1]` stays high.
- R3: A write with address bit 0 = 1 pulls only `sramWeN[1]` low, and a later read of the neighbouring even byte still returns its earlier value.
- R4: A lane strobe is low only while `cpuPhase` is 1, so a write held for one CPU cycle (two fast cycles) gives exactly one fast cycle of strobe.
- R5: `sramCeN` is low exactly when chip select is high and reset is low; during reset it stays high even with chip select asserted.
- R6: During a write, only the addressed lane has its `sramDoe` bit set and carries the CPU byte on `sramDout`; the other lane's enable is 0 (high impedance).
- R7: A read returns `sramDin[7:0]` when address bit 0 is 0 and `sramDin[15:8]` when it is 1; a read sets no strobe and no output enable.
- R8: With chip select low, both strobes are high and both output enables are 0.
- R9: `cpuPhase` is 0 during reset and toggles on every fast clock edge afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the CPU rate |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | RAM selected by the CPU |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 18 | CPU byte address |
| wdata | input | 8 | CPU write byte |
| rdata | output | 8 | Byte returned to the CPU |
| cpuPhase | output | 1 | Derived CPU-clock phase |
| sramAddr | output | 17 | SRAM word address |
| sramCeN | output | 1 | SRAM chip enable, active low |
| sramWeN | output | 2 | Lane write strobes, active low, bit 0 = lower lane |
| sramDout | output | 16 | Data driven toward the SRAM |
| sramDoe | output | 2 | Per-lane output enable, bit 0 = bits 7..0 |
| sramDin | input | 16 | Data read back from the SRAM pins |

## Verification
The bench uses the default parameters: an 18-bit byte address, 8-bit lanes and two lanes. These reach both lane polarities and the all-ones top word address. A behavioural SRAM in the bench latches a lane only when the chip enable, that lane's strobe and its enable are active together. Writes and reads therefore check the lane steering end to end. Back-to-back writes to both lanes of the same word, and a read of a lane that was never written, show that one lane's write leaves the other lane untouched.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic chipOn;   // selected and out of reset
    logic wrCycle;  // whole CPU write cycle
    logic wrPulse;  // write, CPU phase high
  } bridgeCtl_t;
endpackage

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rw,
  output bridgeCtl_t ctl,
  output logic       cpuPhase,
  output logic       ceN
);
  logic phaseQ;

  // Half-rate phase: the CPU clock seen from the fast domain
  always_ff @(posedge clk) begin
    if (rst) phaseQ <= 1'b0;
    else     phaseQ <= ~phaseQ;
  end

  always_comb begin
    ctl.chipOn  = cs & ~rst;
    ctl.wrCycle = cs & ~rw;
    ctl.wrPulse = cs & ~rw & phaseQ;
  end

  assign cpuPhase = phaseQ;
  assign ceN      = ~ctl.chipOn;
endmodule

// File: rtl/sram_bridge_dpath.sv
module sram_bridge_dpath
  import sram_bridge_pkg::*;
#(
  parameter int BYTE_ADDR_W = 18,
  parameter int BYTE_W      = 8,
  parameter int LANES       = 2
) (
  input  bridgeCtl_t                    ctl,
  input  logic [BYTE_ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic [LANES*BYTE_W-1:0]       sramDin,
  output logic [BYTE_ADDR_W-$clog2(LANES)-1:0] sramAddr,
  output logic [LANES-1:0]              weN,
  output logic [LANES*BYTE_W-1:0]       dout,
  output logic [LANES-1:0]              doe,
  output logic [BYTE_W-1:0]             rdata
);
  localparam int LANE_SEL_W = $clog2(LANES);

  logic [LANE_SEL_W-1:0] laneSel;
  assign laneSel  = addr[LANE_SEL_W-1:0];
  assign sramAddr = addr[BYTE_ADDR_W-1:LANE_SEL_W];

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic hit;
    assign hit = (laneSel == LANE_SEL_W'(lane));
    assign weN[lane] = ~(ctl.chipOn & ctl.wrPulse & hit);
    assign doe[lane] = ctl.chipOn & ctl.wrCycle & hit;
    assign dout[lane*BYTE_W +: BYTE_W] = wdata;
  end

  always_comb begin
    rdata = sramDin[laneSel*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sram_lane_bridge.sv
module sram_lane_bridge
  import sram_bridge_pkg::*;
#(
  parameter int BYTE_ADDR_W = 18,
  parameter int BYTE_W      = 8,
  parameter int LANES       = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cs,
  input  logic                                  rw,
  input  logic [BYTE_ADDR_W-1:0]                addr,
  input  logic [BYTE_W-1:0]                     wdata,
  output logic [BYTE_W-1:0]                     rdata,
  output logic                                  cpuPhase,
  output logic [BYTE_ADDR_W-$clog2(LANES)-1:0]  sramAddr,
  output logic                                  sramCeN,
  output logic [LANES-1:0]                      sramWeN,
  output logic [LANES*BYTE_W-1:0]               sramDout,
  output logic [LANES-1:0]                      sramDoe,
  input  logic [LANES*BYTE_W-1:0]               sramDin
);
  bridgeCtl_t ctl;

  sram_bridge_ctrl uCtrl (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw),
    .ctl(ctl), .cpuPhase(cpuPhase), .ceN(sramCeN)
  );

  sram_bridge_dpath #(
    .BYTE_ADDR_W(BYTE_ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)
  ) uDpath (
    .ctl(ctl), .addr(addr), .wdata(wdata), .sramDin(sramDin),
    .sramAddr(sramAddr), .weN(sramWeN), .dout(sramDout),
    .doe(sramDoe), .rdata(rdata)
  );
endmodule

// File: rtl/sram_lane_bridge_chk.sv
module sram_lane_bridge_chk #(
  parameter int BYTE_ADDR_W = 18,
  parameter int BYTE_W      = 8,
  parameter int LANES       = 2
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 cs,
  input logic                                 rw,
  input logic [BYTE_ADDR_W-1:0]               addr,
  input logic                                 cpuPhase,
  input logic [BYTE_ADDR_W-$clog2(LANES)-1:0] sramAddr,
  input logic                                 sramCeN,
  input logic [LANES-1:0]                     sramWeN,
  input logic [LANES-1:0]                     sramDoe
);
  // R2 / R3: never more than one lane strobed
  assert_single_lane_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~sramWeN) <= 1);

  // R4: strobes confined to the high CPU phase, inside a write
  assert_strobe_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (~&sramWeN) |-> (cpuPhase && cs && !rw));

  // R6: a strobed lane is also driven and the chip enabled
  assert_strobe_driven_R6: assert property (@(posedge clk) disable iff (rst)
    (~&sramWeN) |-> ((sramDoe == ~sramWeN) && !sramCeN));

  // R6: at most one lane driven
  assert_one_driver_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sramDoe));

  // R5: chip enable only with chip select
  assert_ce_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !sramCeN |-> cs);

  // R8: idle bus stays quiet
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (&sramWeN && sramDoe == '0));

  // R7: reads drive nothing
  assert_read_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (cs && rw) |-> (&sramWeN && sramDoe == '0));

  // R9: phase toggles every fast edge
  assert_phase_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpuPhase != $past(cpuPhase)));

  // R1: word address follows byte address
  assert_word_addr_R1: assert property (@(posedge clk) disable iff (rst)
    cs |-> (sramAddr == addr[BYTE_ADDR_W-1:$clog2(LANES)]));
endmodule

bind sram_lane_bridge sram_lane_bridge_chk #(
  .BYTE_ADDR_W(BYTE_ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)
) uChk (
  .clk(clk), .rst(rst), .cs(cs), .rw(rw), .addr(addr),
  .cpuPhase(cpuPhase), .sramAddr(sramAddr), .sramCeN(sramCeN),
  .sramWeN(sramWeN), .sramDoe(sramDoe)
);

// File: tb/sim_sram_lane_bridge.sv
module sim_sram_lane_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0;
  logic        rw = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cpuPhase;
  logic [16:0] sramAddr;
  logic        sramCeN;
  logic [1:0]  sramWeN;
  logic [15:0] sramDout;
  logic [1:0]  sramDoe;
  logic [15:0] sramDin;

  int vecCount = 0;
  int badCount = 0;
  int memVer = 0;
  logic [15:0] mem [int];
  logic [7:0]  shadow [int];

  always #2 clk = ~clk;  // 250 MHz

  sram_lane_bridge u0 (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cpuPhase(cpuPhase), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramDout(sramDout),
    .sramDoe(sramDoe), .sramDin(sramDin)
  );

  // Behavioural SRAM: a lane latches on strobe + enable + drive
  always @(posedge clk) begin
    if (!sramCeN) begin
      for (int l = 0; l < 2; l++) begin
        if (!sramWeN[l] && sramDoe[l]) begin
          logic [15:0] w;
          w = mem.exists(int'(sramAddr)) ? mem[int'(sramAddr)] : 16'h0000;
          w[l*8 +: 8] = sramDout[l*8 +: 8];
          mem[int'(sramAddr)] = w;
          memVer = memVer + 1;
        end
      end
    end
  end

  always @(sramAddr or memVer) begin
    sramDin = mem.exists(int'(sramAddr)) ? mem[int'(sramAddr)] : 16'h0000;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      badCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alignLow();
    @(negedge clk);
    while (cpuPhase) @(negedge clk);
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [7:0] d);
    int strobes = 0;
    logic [1:0] expWe;
    alignLow();
    cs = 1'b1; rw = 1'b0; addr = a; wdata = d;
    expWe = a[0] ? 2'b01 : 2'b10;
    #1;
    if (!(&sramWeN)) strobes++;
    chk(&sramWeN, "R4 no strobe in low phase", sramWeN, 2'b11);
    chk(sramDoe == ~expWe, "R6 lane enable", sramDoe, ~expWe);
    chk(sramDout[a[0]*8 +: 8] == d, "R6 lane data", sramDout, d);
    chk(sramAddr == a[17:1], "R1 word address", sramAddr, a[17:1]);
    chk(!sramCeN, "R5 ce during write", sramCeN, 0);
    @(negedge clk); #1;
    if (!(&sramWeN)) strobes++;
    chk(sramWeN == expWe, a[0] ? "R3 upper strobe" : "R2 lower strobe",
        sramWeN, expWe);
    chk(strobes == 1, "R4 one strobe per cycle", strobes, 1);
    shadow[int'(a)] = d;
  endtask

  task automatic doRead(input logic [17:0] a, input string req);
    logic [7:0] exp;
    alignLow();
    cs = 1'b1; rw = 1'b1; addr = a;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    #1;
    chk(rdata == exp, req, rdata, exp);
    chk(&sramWeN && sramDoe == 2'b00, "R7 read quiet", {sramWeN, sramDoe}, 4'b1100);
    @(negedge clk); #1;
    chk(&sramWeN, "R7 read no strobe high phase", sramWeN, 2'b11);
  endtask

  task automatic testReset();
    cs = 1'b1; rw = 1'b0;
    @(negedge clk); #1;
    chk(sramCeN, "R5 ce off in reset", sramCeN, 1);
    chk(!cpuPhase, "R9 phase low in reset", cpuPhase, 0);
    chk(sramDoe == 2'b00, "R5 no drive in reset", sramDoe, 0);
    cs = 1'b0; rw = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk(cpuPhase, "R9 phase after reset", cpuPhase, 1);
    @(negedge clk); #1;
    chk(!cpuPhase, "R9 phase toggles", cpuPhase, 0);
  endtask

  task automatic testIdle();
    alignLow();
    cs = 1'b0; rw = 1'b0; addr = 18'h00011; wdata = 8'hEE;
    #1;
    chk(&sramWeN && sramDoe == 2'b00 && sramCeN, "R8 idle low phase",
        {sramCeN, sramWeN, sramDoe}, 5'b11100);
    @(negedge clk); #1;
    chk(&sramWeN && sramDoe == 2'b00, "R8 idle high phase", {sramWeN, sramDoe}, 4'b1100);
    cs = 1'b1; rw = 1'b1; addr = 18'h00011;
    #1;
    chk(rdata == 8'h00, "R8 idle write left memory unchanged", rdata, 0);
    cs = 1'b0;
  endtask

  task automatic testLanes();
    doWrite(18'h00010, 8'hA5);
    doWrite(18'h00011, 8'h3C);
    doRead(18'h00010, "R3 even byte kept after odd write");
    doRead(18'h00011, "R7 upper lane read");
    doWrite(18'h00010, 8'h5A);
    doRead(18'h00011, "R2 odd byte kept after even write");
    doRead(18'h00010, "R7 lower lane read");
    doRead(18'h00021, "R7 unwritten lane reads zero");
    cs = 1'b0;
  endtask

  task automatic testTopWord();
    doWrite(18'h3FFFF, 8'hC3);
    doWrite(18'h3FFFE, 8'h81);
    doRead(18'h3FFFF, "R1 top word upper");
    doRead(18'h3FFFE, "R1 top word lower");
    cs = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    badCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

  initial begin
    testReset();
    testIdle();
    testLanes();
    testTopWord();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end
endmodule